// File: doc/BRIEF.md
# Next-PC Sequencer with Hardware Loop and Breakpoint Trap

This block picks the program counter of the next instruction each time an instruction is stepped. It gets the current PC, the sequential successor, and a branch-taken flag with its target from the execution pipeline. It then applies three more layers of redirect, in priority order:

- a zero-overhead repeat loop, driven by an end-address compare and a countdown;
- an instruction breakpoint, which overrides any pending branch or loop target;
- fault vectoring for bus errors and illegal instructions.

On every trap it computes a new status word for the register file to load. It also keeps the return PC and the old status word in its own backup registers. All PCs are word addresses, and the vector entries are parameters.

Software-side logic arms the loop in one strobe: start address, end address and iteration count. It arms the breakpoint with a second strobe: enable bit and address. The execution unit drives `step` for each retiring instruction and loads `next_pc` as the new PC. It writes `psw_next` into the status word whenever `psw_we` is high.

Top module: `pc_redirect_ctrl`

## Requirements
- R1: After reset, loop_active, dbg_active, loop_count, save_pc and save_psw are all zero.
- R2: On a step with no fault, no breakpoint hit and no loop redirect, next_pc equals br_target when br_taken is 1 and seq_pc otherwise, and psw_we is 0; with step low, next_pc equals seq_pc.
- R3: On a step where the loop is active, br_taken is 0, cur_pc equals the loop end address and the count is above 1, next_pc is the loop start address and the count drops by one after the clock edge.
- R4: On such a step with a count of exactly 1, next_pc is seq_pc and, after the edge, loop_active is 0 and loop_count is 0.
- R5: A taken branch at the loop end address wins: next_pc is br_target and the loop count and active bit stay unchanged.
- R6: When dbg_active is 1 and cur_pc equals the breakpoint address on a step without a fault, next_pc is DBG_VEC and psw_we is 1. psw_next keeps only bit 15 of psw_cur (the stack-mode bit). After the edge, save_pc holds the target that would otherwise have been taken, save_psw holds psw_cur, and dbg_active and loop_active are 0.
- R7: A step with exc_bus set goes to BUS_VEC with psw_we 1. psw_next keeps only bits 3, 2 and 0 of psw_cur (F0, F1, carry). After the edge, save_pc is cur_pc, save_psw is psw_cur, and the loop and debug active bits are cleared. A bus error beats an illegal instruction and a breakpoint.
- R8: A step with exc_ill set (and exc_bus clear) goes to ILL_VEC with the same status-word reduction and saves as R7.
- R9: With step low and no load strobe, loop_count, loop_active, dbg_active, save_pc and save_psw hold their values.
- R10: lp_load writes start, end and count; loop_active becomes 1 only if the loaded count is nonzero. A load strobe overrides the step update in the same cycle.
- R11: With the breakpoint disabled, a step at the breakpoint address behaves as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | An instruction retires this cycle |
| cur_pc | input | PC_W | PC of the retiring instruction |
| seq_pc | input | PC_W | Sequential successor PC |
| br_taken | input | 1 | The instruction changed the PC itself |
| br_target | input | PC_W | Branch target |
| exc_bus | input | 1 | Bus-error event |
| exc_ill | input | 1 | Illegal-instruction event |
| psw_cur | input | 16 | Current status word |
| lp_load | input | 1 | Arm loop registers |
| lp_start | input | PC_W | Loop start address |
| lp_end | input | PC_W | Loop end address |
| lp_count | input | CNT_W | Loop iteration count |
| bp_load | input | 1 | Write breakpoint registers |
| bp_enable | input | 1 | Breakpoint enable value |
| bp_addr | input | PC_W | Breakpoint address |
| next_pc | output | PC_W | PC for the next instruction |
| psw_we | output | 1 | Load psw_next into the status word |
| psw_next | output | 16 | Reduced status word on a trap |
| loop_active | output | 1 | Repeat loop armed |
| loop_count | output | CNT_W | Remaining iterations |
| dbg_active | output | 1 | Breakpoint armed |
| save_pc | output | PC_W | Return PC of the last trap |
| save_psw | output | 16 | Status word before the last trap |

## Verification
Properties check on every cycle that a loop-end step decrements the count or exits at one, that a branch at the loop end wins, that a bus error always vectors, and that loop state is frozen between steps. Priority between simultaneous faults, the exact status-word masks, the return address saved on a breakpoint (the loop target rather than the sequential PC), and the clearing of the armed bits by traps are shown only by the bench's scenarios.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int PSW_W  = 16;
    localparam int SM_BIT = 15;
    localparam int F0_BIT = 3;
    localparam int F1_BIT = 2;
    localparam int CY_BIT = 0;

    localparam logic [PSW_W-1:0] FAULT_KEEP = (PSW_W'(1) << F0_BIT) | (PSW_W'(1) << F1_BIT) | (PSW_W'(1) << CY_BIT);
    localparam logic [PSW_W-1:0] DBG_KEEP   = PSW_W'(1) << SM_BIT;

    typedef enum logic [1:0] {
        TRAP_NONE = 2'd0,
        TRAP_BUS  = 2'd1,
        TRAP_ILL  = 2'd2,
        TRAP_DBG  = 2'd3
    } trap_e;
endpackage

// File: rtl/pc_loop_eval.sv
module pc_loop_eval #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input  logic             active,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  end_pc,
    input  logic [CNT_W-1:0] count,
    output logic             redirect,
    output logic             active_nxt,
    output logic [CNT_W-1:0] count_nxt
);
    logic at_end;

    always_comb begin
        at_end     = active && !br_taken && (cur_pc == end_pc);
        redirect   = 1'b0;
        active_nxt = active;
        count_nxt  = count;
        if (at_end) begin
            if (count > CNT_W'(1)) begin
                redirect  = 1'b1;
                count_nxt = count - CNT_W'(1);
            end else begin
                active_nxt = 1'b0;
                count_nxt  = '0;
            end
        end
    end
endmodule

// File: rtl/pc_trap_sel.sv
module pc_trap_sel
    import npc_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter logic [PC_W-1:0] BUS_VEC = 'h0FF0,
    parameter logic [PC_W-1:0] ILL_VEC = 'h0FF4,
    parameter logic [PC_W-1:0] DBG_VEC = 'h0FF8
) (
    input  logic             step,
    input  logic             exc_bus,
    input  logic             exc_ill,
    input  logic             dbg_hit,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  pending_pc,
    input  logic [PSW_W-1:0] psw_cur,
    output trap_e            kind,
    output logic [PC_W-1:0]  next_pc,
    output logic             psw_we,
    output logic [PSW_W-1:0] psw_next,
    output logic [PC_W-1:0]  ret_pc
);
    always_comb begin
        kind = TRAP_NONE;
        if (step) begin
            if (exc_bus)      kind = TRAP_BUS;
            else if (exc_ill) kind = TRAP_ILL;
            else if (dbg_hit) kind = TRAP_DBG;
        end
        case (kind)
            TRAP_BUS: begin
                next_pc  = BUS_VEC;
                psw_next = psw_cur & FAULT_KEEP;
            end
            TRAP_ILL: begin
                next_pc  = ILL_VEC;
                psw_next = psw_cur & FAULT_KEEP;
            end
            TRAP_DBG: begin
                next_pc  = DBG_VEC;
                psw_next = psw_cur & DBG_KEEP;
            end
            default: begin
                next_pc  = pending_pc;
                psw_next = psw_cur;
            end
        endcase
        psw_we = (kind != TRAP_NONE);
        ret_pc = (kind == TRAP_DBG) ? pending_pc : cur_pc;
    end
endmodule

// File: rtl/pc_redirect_ctrl.sv
module pc_redirect_ctrl
    import npc_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter int              CNT_W   = 16,
    parameter logic [PC_W-1:0] BUS_VEC = 'h0FF0,
    parameter logic [PC_W-1:0] ILL_VEC = 'h0FF4,
    parameter logic [PC_W-1:0] DBG_VEC = 'h0FF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  seq_pc,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic             exc_bus,
    input  logic             exc_ill,
    input  logic [15:0]      psw_cur,
    input  logic             lp_load,
    input  logic [PC_W-1:0]  lp_start,
    input  logic [PC_W-1:0]  lp_end,
    input  logic [CNT_W-1:0] lp_count,
    input  logic             bp_load,
    input  logic             bp_enable,
    input  logic [PC_W-1:0]  bp_addr,
    output logic [PC_W-1:0]  next_pc,
    output logic             psw_we,
    output logic [15:0]      psw_next,
    output logic             loop_active,
    output logic [CNT_W-1:0] loop_count,
    output logic             dbg_active,
    output logic [PC_W-1:0]  save_pc,
    output logic [15:0]      save_psw
);
    typedef struct packed {
        logic [PC_W-1:0]  lp_first;
        logic [PC_W-1:0]  lp_last;
        logic [CNT_W-1:0] cnt;
        logic             act;
        logic [PC_W-1:0]  brk;
        logic             dbg;
        logic [PC_W-1:0]  spc;
        logic [PSW_W-1:0] spsw;
    } state_t;

    state_t st_q, st_d;

    logic             lp_redirect, lp_act_nxt, dbg_hit;
    logic [CNT_W-1:0] lp_cnt_nxt;
    logic [PC_W-1:0]  pending_pc, ret_pc;
    trap_e            kind;

    pc_loop_eval #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
        .active     (st_q.act),
        .br_taken   (br_taken),
        .cur_pc     (cur_pc),
        .end_pc     (st_q.lp_last),
        .count      (st_q.cnt),
        .redirect   (lp_redirect),
        .active_nxt (lp_act_nxt),
        .count_nxt  (lp_cnt_nxt)
    );

    always_comb begin
        dbg_hit = st_q.dbg && (cur_pc == st_q.brk);
        if (!step)            pending_pc = seq_pc;
        else if (lp_redirect) pending_pc = st_q.lp_first;
        else if (br_taken)    pending_pc = br_target;
        else                  pending_pc = seq_pc;
    end

    pc_trap_sel #(.PC_W(PC_W), .BUS_VEC(BUS_VEC), .ILL_VEC(ILL_VEC), .DBG_VEC(DBG_VEC)) u_trap (
        .step       (step),
        .exc_bus    (exc_bus),
        .exc_ill    (exc_ill),
        .dbg_hit    (dbg_hit),
        .cur_pc     (cur_pc),
        .pending_pc (pending_pc),
        .psw_cur    (psw_cur),
        .kind       (kind),
        .next_pc    (next_pc),
        .psw_we     (psw_we),
        .psw_next   (psw_next),
        .ret_pc     (ret_pc)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (kind == TRAP_NONE || kind == TRAP_DBG) st_d.cnt = lp_cnt_nxt;
            if (kind == TRAP_NONE) begin
                st_d.act = lp_act_nxt;
            end else begin
                st_d.act  = 1'b0;
                st_d.dbg  = 1'b0;
                st_d.spc  = ret_pc;
                st_d.spsw = psw_cur;
            end
        end
        if (lp_load) begin
            st_d.lp_first = lp_start;
            st_d.lp_last  = lp_end;
            st_d.cnt      = lp_count;
            st_d.act      = (lp_count != '0);
        end
        if (bp_load) begin
            st_d.brk = bp_addr;
            st_d.dbg = bp_enable;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign loop_active = st_q.act;
    assign loop_count  = st_q.cnt;
    assign dbg_active  = st_q.dbg;
    assign save_pc     = st_q.spc;
    assign save_psw    = st_q.spsw;

    a_r3_loop_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.act && cur_pc == st_q.lp_last && !br_taken && !exc_bus && !exc_ill
         && !lp_load && st_q.cnt > CNT_W'(1))
        |=> (loop_count == $past(loop_count) - CNT_W'(1)));

    a_r4_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.act && cur_pc == st_q.lp_last && !br_taken && !exc_bus && !exc_ill
         && !lp_load && st_q.cnt == CNT_W'(1))
        |=> (!loop_active && loop_count == '0));

    a_r5_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (step && br_taken && !exc_bus && !exc_ill && !(st_q.dbg && cur_pc == st_q.brk))
        |-> (next_pc == br_target && !psw_we));

    a_r7_bus_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (step && exc_bus) |-> (next_pc == BUS_VEC && psw_we));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !lp_load && !bp_load)
        |=> ($stable(loop_count) && $stable(loop_active) && $stable(save_pc) && $stable(dbg_active)));
endmodule

// File: tb/pc_redirect_ctrl_tb.sv
module pc_redirect_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BUS_V = 16'h0FF0;
    localparam logic [15:0] ILL_V = 16'h0FF4;
    localparam logic [15:0] DBG_V = 16'h0FF8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 0, br_taken = 0, exc_bus = 0, exc_ill = 0, lp_load = 0, bp_load = 0, bp_enable = 0;
    logic [15:0] cur_pc = 0, seq_pc = 0, br_target = 0, psw_cur = 0, lp_start = 0, lp_end = 0, lp_count = 0, bp_addr = 0;
    logic [15:0] next_pc, psw_next, loop_count, save_pc, save_psw;
    logic psw_we, loop_active, dbg_active;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_redirect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .step(step), .cur_pc(cur_pc), .seq_pc(seq_pc),
        .br_taken(br_taken), .br_target(br_target), .exc_bus(exc_bus), .exc_ill(exc_ill),
        .psw_cur(psw_cur), .lp_load(lp_load), .lp_start(lp_start), .lp_end(lp_end),
        .lp_count(lp_count), .bp_load(bp_load), .bp_enable(bp_enable), .bp_addr(bp_addr),
        .next_pc(next_pc), .psw_we(psw_we), .psw_next(psw_next), .loop_active(loop_active),
        .loop_count(loop_count), .dbg_active(dbg_active), .save_pc(save_pc), .save_psw(save_psw)
    );

    typedef struct packed {
        logic        stp;
        logic [15:0] cur;
        logic [15:0] seq;
        logic        br;
        logic [15:0] tgt;
        logic        eb;
        logic        ei;
        logic [15:0] psw;
        logic [15:0] exp_pc;
        logic        exp_we;
        logic [15:0] exp_psw;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b1, 16'h0100, 16'h0101, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h8005, 16'h0101, 1'b0, 16'h0000},
        '{1'b1, 16'h0200, 16'h0201, 1'b1, 16'h0400, 1'b0, 1'b0, 16'h0000, 16'h0400, 1'b0, 16'h0000},
        '{1'b1, 16'h0300, 16'h0301, 1'b0, 16'h0000, 1'b1, 1'b0, 16'hFFFF, 16'h0FF0, 1'b1, 16'h000D},
        '{1'b1, 16'h0310, 16'h0311, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h8009, 16'h0FF4, 1'b1, 16'h0009},
        '{1'b1, 16'h0320, 16'h0321, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0004, 16'h0FF0, 1'b1, 16'h0004},
        '{1'b1, 16'h0330, 16'h0331, 1'b1, 16'h0500, 1'b0, 1'b1, 16'hF0F2, 16'h0FF4, 1'b1, 16'h0000},
        '{1'b0, 16'h0100, 16'h0101, 1'b1, 16'h0777, 1'b1, 1'b0, 16'h1234, 16'h0101, 1'b0, 16'h0000},
        '{1'b1, 16'h0340, 16'h0341, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 16'h0FF0, 1'b1, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        step = 0; br_taken = 0; exc_bus = 0; exc_ill = 0; lp_load = 0; bp_load = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_step(input logic [15:0] c, input logic [15:0] s, input logic b, input logic [15:0] t);
        step = 1; cur_pc = c; seq_pc = s; br_taken = b; br_target = t;
        #1;
    endtask

    task automatic load_loop(input logic [15:0] a, input logic [15:0] e, input logic [15:0] n);
        lp_load = 1; lp_start = a; lp_end = e; lp_count = n;
        tick();
    endtask

    task automatic load_bp(input logic en, input logic [15:0] a);
        bp_load = 1; bp_enable = en; bp_addr = a;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 loop_active", loop_active, 0);
        chk("R1 dbg_active", dbg_active, 0);
        chk("R1 loop_count", loop_count, 0);
        chk("R1 save_pc", save_pc, 0);
        chk("R1 save_psw", save_psw, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 / R7 / R8 table
        for (int i = 0; i < 8; i++) begin
            step = TBL[i].stp; cur_pc = TBL[i].cur; seq_pc = TBL[i].seq; br_taken = TBL[i].br;
            br_target = TBL[i].tgt; exc_bus = TBL[i].eb; exc_ill = TBL[i].ei; psw_cur = TBL[i].psw;
            #1;
            chk("R2/R7/R8 next_pc", next_pc, TBL[i].exp_pc);
            chk("R2/R7/R8 psw_we", psw_we, TBL[i].exp_we);
            if (TBL[i].exp_we) chk("R7/R8 psw_next", psw_next, TBL[i].exp_psw);
            tick();
            if (TBL[i].exp_we) begin
                chk("R7/R8 save_pc", save_pc, TBL[i].cur);
                chk("R7/R8 save_psw", save_psw, TBL[i].psw);
            end
        end

        // R10 zero count does not arm
        load_loop(16'h0020, 16'h0023, 16'd0);
        chk("R10 zero count inactive", loop_active, 0);
        load_loop(16'h0020, 16'h0023, 16'd3);
        chk("R10 armed", loop_active, 1);
        chk("R10 count", loop_count, 3);

        // R3 redirect
        do_step(16'h0023, 16'h0024, 0, 16'h0);
        chk("R3 next_pc", next_pc, 16'h0020);
        tick();
        chk("R3 count", loop_count, 2);

        // R9 no step, no change
        cur_pc = 16'h0023; #1;
        tick();
        chk("R9 count held", loop_count, 2);
        chk("R9 active held", loop_active, 1);

        // R5 branch at end
        do_step(16'h0023, 16'h0024, 1, 16'h0050);
        chk("R5 next_pc", next_pc, 16'h0050);
        tick();
        chk("R5 count unchanged", loop_count, 2);
        chk("R5 active unchanged", loop_active, 1);

        do_step(16'h0023, 16'h0024, 0, 16'h0);
        chk("R3 second pass", next_pc, 16'h0020);
        tick();
        chk("R3 count 1", loop_count, 1);

        // R4 exit on last
        do_step(16'h0023, 16'h0024, 0, 16'h0);
        chk("R4 fall through", next_pc, 16'h0024);
        tick();
        chk("R4 inactive", loop_active, 0);
        chk("R4 count zero", loop_count, 0);
        do_step(16'h0023, 16'h0024, 0, 16'h0);
        chk("R4 no redirect after exit", next_pc, 16'h0024);
        tick();

        // R11 disabled breakpoint
        load_bp(0, 16'h0040);
        do_step(16'h0040, 16'h0041, 0, 16'h0);
        chk("R11 next_pc", next_pc, 16'h0041);
        chk("R11 psw_we", psw_we, 0);
        tick();

        // R6 breakpoint overriding loop redirect
        load_bp(1, 16'h0040);
        chk("R6 armed", dbg_active, 1);
        load_loop(16'h0030, 16'h0040, 16'd5);
        psw_cur = 16'h8123;
        do_step(16'h0040, 16'h0041, 0, 16'h0);
        chk("R6 next_pc", next_pc, DBG_V);
        chk("R6 psw_we", psw_we, 1);
        chk("R6 psw_next", psw_next, 16'h8000);
        tick();
        chk("R6 save_pc", save_pc, 16'h0030);
        chk("R6 save_psw", save_psw, 16'h8123);
        chk("R6 dbg cleared", dbg_active, 0);
        chk("R6 loop cleared", loop_active, 0);

        // R7 bus beats breakpoint, clears loop
        load_bp(1, 16'h0060);
        load_loop(16'h0058, 16'h0060, 16'd4);
        psw_cur = 16'h000F;
        exc_bus = 1;
        do_step(16'h0060, 16'h0061, 1, 16'h0099);
        chk("R7 bus over bp", next_pc, BUS_V);
        chk("R7 psw_next", psw_next, 16'h000D);
        tick();
        chk("R7 save_pc", save_pc, 16'h0060);
        chk("R7 loop cleared", loop_active, 0);
        chk("R7 dbg cleared", dbg_active, 0);

        // R8 illegal over breakpoint
        load_bp(1, 16'h0070);
        exc_ill = 1; psw_cur = 16'h800C;
        do_step(16'h0070, 16'h0071, 0, 16'h0);
        chk("R8 next_pc", next_pc, ILL_V);
        chk("R8 psw_next", psw_next, 16'h000C);
        tick();
        chk("R8 save_pc", save_pc, 16'h0070);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule